// File: doc/BRIEF.md
# Periodic Interrupt Tick Generator

This block divides a 32768 Hz timebase, delivered as a one-cycle enable pulse on the system clock, into a periodic tick. A 4-bit rate selector sets the tick rate. Each tick produces a one-cycle pulse that asks a separate register block to set its periodic flag. When the periodic-interrupt enable is set, a second pulse asks that block to set its master interrupt flag and raise the interrupt line. The block also reports the current period length, counted in timebase cycles.

The ticks are not timed from the moment the rate is written. A free-running 14-bit binary count advances on every timebase pulse. A tick fires whenever that count reaches a multiple of the selected period. Changing the rate therefore takes effect at the next boundary of the new period. A divider-hold setting on the divider-select input freezes the count at zero and stops all ticks.

Top module: `periodic_irq_gen`

## Requirements
- R1: A rate code of 0 produces no flag pulses and no interrupt pulses, whatever the other inputs are.
- R2: Rate code 1 behaves exactly as code 8 (period 128), and rate code 2 behaves exactly as code 9 (period 256).
- R3: For rate codes 3 to 15, `period` equals 2^(code-1) timebase cycles, so code 3 gives 4 and code 15 gives 16384.
- R4: The 14-bit count advances by one, with wrap, on every `tick_en` cycle outside divider hold. This happens whatever the rate and the enable are. A tick occurs on a `tick_en` cycle whose new count value has its low (log2 period) bits all zero. `pf_set` is high for exactly the one clock after that `tick_en` cycle.
- R5: `irq_set` pulses only in the same cycle as `pf_set`.
- R6: With `per_int_en` low, no ticks are produced, but the count keeps running.
- R7: When `div_sel[2:1]` is 2'b11, divider hold is active: the count is forced to zero and no ticks are produced. After release, the first tick comes on the period-th `tick_en` pulse.
- R8: A change of rate code takes effect at the next multiple of the new period on the running count. No extra pulse is produced.
- R9: After reset, `pf_set` and `irq_set` are low and the count is zero.
- R10: `period` reads 0 while the rate code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the 32768 Hz timebase rate |
| rate_sel | input | 4 | Rate code; 0 disables ticks |
| per_int_en | input | 1 | Periodic interrupt enable |
| div_sel | input | 3 | Divider select; bits 2:1 equal to 11 hold the divider |
| pf_set | output | 1 | Pulse: set the periodic flag |
| irq_set | output | 1 | Pulse: set the master flag and raise the interrupt line |
| period | output | 15 | Current period in timebase cycles, 0 when disabled |

## Verification
The bench targets the aliased codes 1 and 2. A design that decoded them linearly would tick every cycle or every second cycle instead of every 128 or 256. It switches rates in the middle of a period. A design that restarted its divider on a rate write would drift off the count's multiples, or emit a stray pulse. It also releases divider hold and runs the longest period through a full count wrap. Here an off-by-one in the mask or counter width shows up as an early, late or missing tick. Random enable gaps and timebase gaps check that the count keeps running while ticks are suppressed.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

   // Divider operating mode decoded from the divider select field.
   typedef enum logic {
      DIV_RUN  = 1'b0,
      DIV_HOLD = 1'b1
   } div_mode_e;

   // Maps a raw rate code onto the effective code, folding the two
   // aliased low codes onto slower rates.
   function automatic int unsigned eff_code(input int unsigned raw,
                                            input int unsigned alias_one,
                                            input int unsigned alias_two);
      if (raw == 1) return alias_one;
      if (raw == 2) return alias_two;
      return raw;
   endfunction

endpackage

// File: rtl/pit_rate_decode.sv
`timescale 1ns/1ps
module pit_rate_decode #(
   parameter int unsigned CODE_W    = 4,
   parameter int unsigned CNT_W     = 14,
   parameter int unsigned PER_W     = 15,
   parameter int unsigned ALIAS_ONE = 8,
   parameter int unsigned ALIAS_TWO = 9
) (
   input  logic [CODE_W-1:0] code,
   output logic              active,
   output logic [CNT_W-1:0]  mask,
   output logic [PER_W-1:0]  period
);
   import pit_pkg::*;

   localparam logic [CODE_W-1:0] A1 = CODE_W'(ALIAS_ONE);
   localparam logic [CODE_W-1:0] A2 = CODE_W'(ALIAS_TWO);

   logic [CODE_W-1:0] eff;
   logic [CODE_W-1:0] shift;

   always_comb begin
      unique case (code)
         CODE_W'(1): eff = A1;
         CODE_W'(2): eff = A2;
         default:    eff = code;
      endcase
      active = (code != '0);
      shift  = active ? (eff - CODE_W'(1)) : '0;
      mask   = (CNT_W'(1) << shift) - CNT_W'(1);
      period = active ? (PER_W'(1) << shift) : '0;
   end

endmodule

// File: rtl/pit_timebase.sv
`timescale 1ns/1ps
module pit_timebase #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_next
);

   assign cnt_next = cnt + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (hold)   cnt <= '0;
      else if (step)   cnt <= cnt_next;
   end

endmodule

// File: rtl/pit_tick_detect.sv
`timescale 1ns/1ps
module pit_tick_detect #(
   parameter int unsigned CNT_W = 14
) (
   input  logic [CNT_W-1:0] cnt_next,
   input  logic [CNT_W-1:0] mask,
   input  logic             step,
   input  logic             hold,
   input  logic             active,
   input  logic             sched_en,
   output logic             tick
);

   logic boundary;

   always_comb begin
      boundary = ((cnt_next & mask) == '0);
      tick     = step && !hold && active && sched_en && boundary;
   end

endmodule

// File: rtl/periodic_irq_gen.sv
`timescale 1ns/1ps
module periodic_irq_gen #(
   parameter int unsigned CODE_W    = 4,
   parameter int unsigned DIV_W     = 3,
   parameter int unsigned ALIAS_ONE = 8,
   parameter int unsigned ALIAS_TWO = 9,
   parameter bit          OUT_REG   = 1'b1,
   parameter int unsigned MAX_CODE_P = (1 << CODE_W) - 1,
   parameter int unsigned PER_W_P    = MAX_CODE_P
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic [CODE_W-1:0]  rate_sel,
   input  logic               per_int_en,
   input  logic [DIV_W-1:0]   div_sel,
   output logic               pf_set,
   output logic               irq_set,
   output logic [PER_W_P-1:0] period
);
   import pit_pkg::*;

   localparam int unsigned CNT_W = MAX_CODE_P - 1;

   // Elaboration-time parameter checks
   if (CODE_W < 2) begin : g_bad_code_w
      $error("periodic_irq_gen: CODE_W must be at least 2");
   end
   if (DIV_W < 2) begin : g_bad_div_w
      $error("periodic_irq_gen: DIV_W must be at least 2");
   end
   if (ALIAS_ONE < 1 || ALIAS_ONE > MAX_CODE_P ||
       ALIAS_TWO < 1 || ALIAS_TWO > MAX_CODE_P) begin : g_bad_alias
      $error("periodic_irq_gen: alias codes out of range");
   end
   if (PER_W_P != CNT_W + 1) begin : g_bad_per_w
      $error("periodic_irq_gen: PER_W_P must not be overridden");
   end

   div_mode_e         div_mode;
   logic              hold;
   logic              active;
   logic [CNT_W-1:0]  mask;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_next;
   logic              tick;
   logic              irq_tick;

   assign div_mode = (div_sel[DIV_W-1 -: 2] == 2'b11) ? DIV_HOLD : DIV_RUN;
   assign hold     = (div_mode == DIV_HOLD);

   pit_rate_decode #(
      .CODE_W   (CODE_W),
      .CNT_W    (CNT_W),
      .PER_W    (PER_W_P),
      .ALIAS_ONE(ALIAS_ONE),
      .ALIAS_TWO(ALIAS_TWO)
   ) u_dec (
      .code  (rate_sel),
      .active(active),
      .mask  (mask),
      .period(period)
   );

   pit_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (hold),
      .step    (tick_en),
      .cnt     (cnt),
      .cnt_next(cnt_next)
   );

   pit_tick_detect #(.CNT_W(CNT_W)) u_det (
      .cnt_next(cnt_next),
      .mask    (mask),
      .step    (tick_en),
      .hold    (hold),
      .active  (active),
      .sched_en(per_int_en),
      .tick    (tick)
   );

   assign irq_tick = tick && per_int_en;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pf_set  <= 1'b0;
            irq_set <= 1'b0;
         end else begin
            pf_set  <= tick;
            irq_set <= irq_tick;
         end
      end
   end else begin : g_out_comb
      assign pf_set  = tick;
      assign irq_set = irq_tick;
   end

endmodule

// File: rtl/periodic_irq_gen_chk.sv
`timescale 1ns/1ps
module periodic_irq_gen_chk #(
   parameter int unsigned CODE_W  = 4,
   parameter int unsigned DIV_W   = 3,
   parameter bit          OUT_REG = 1'b1,
   parameter int unsigned PER_W_P = 15
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick_en,
   input logic [CODE_W-1:0]  rate_sel,
   input logic               per_int_en,
   input logic [DIV_W-1:0]   div_sel,
   input logic               pf_set,
   input logic               irq_set,
   input logic [PER_W_P-1:0] period
);

   logic hold_seen;
   assign hold_seen = (div_sel[DIV_W-1 -: 2] == 2'b11);

   // R10
   period_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == '0) |-> (period == '0));

   // R3
   period_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel != '0) |-> ($countones(period) == 1));

   // R5
   irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |-> pf_set);

   if (OUT_REG) begin : g_seq
      // R1
      code_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rate_sel == '0) |=> !pf_set);

      // R6
      enable_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !per_int_en |=> !pf_set);

      // R7
      hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hold_seen |=> !pf_set);

      // R4
      needs_timebase_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !tick_en |=> !pf_set);

      // R4
      single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pf_set |=> !pf_set || $past(tick_en));
   end

endmodule

bind periodic_irq_gen periodic_irq_gen_chk #(
   .CODE_W (CODE_W),
   .DIV_W  (DIV_W),
   .OUT_REG(OUT_REG),
   .PER_W_P(PER_W_P)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .rate_sel  (rate_sel),
   .per_int_en(per_int_en),
   .div_sel   (div_sel),
   .pf_set    (pf_set),
   .irq_set   (irq_set),
   .period    (period)
);

// File: tb/periodic_irq_gen_test.sv
`timescale 1ns/1ps
module periodic_irq_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [3:0]  rate_sel = 4'd0;
   logic        per_int_en = 1'b0;
   logic [2:0]  div_sel = 3'b010;
   logic        pf_set;
   logic        irq_set;
   logic [14:0] period;

   int checks = 0;
   int fails  = 0;
   logic [13:0] mcnt = '0;

   periodic_irq_gen uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
      .per_int_en(per_int_en), .div_sel(div_sel), .pf_set(pf_set),
      .irq_set(irq_set), .period(period)
   );

   always #4 clk = ~clk;

   function automatic int eff(input logic [3:0] c);
      if (c == 4'd1) return 8;
      if (c == 4'd2) return 9;
      return int'(c);
   endfunction

   function automatic logic [14:0] exp_period(input logic [3:0] c);
      if (c == 4'd0) return 15'd0;
      return 15'd1 << (eff(c) - 1);
   endfunction

   function automatic logic [13:0] exp_mask(input logic [3:0] c);
      return 14'((15'd1 << (eff(c) - 1)) - 15'd1);
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // Drive one cycle of inputs (called at a falling edge), check the
   // period output, then check the registered pulses one clock later.
   task automatic step(input logic tbe, input logic [3:0] code, input logic pe,
                       input logic [2:0] dv, input string req);
      logic        hold;
      logic        exp_pf;
      logic [13:0] nxt;
      string       tag;
      string       ptag;
      tick_en = tbe; rate_sel = code; per_int_en = pe; div_sel = dv;
      #1;
      ptag = (code == 0) ? "R10" : (code <= 2) ? "R2" : "R3";
      check(ptag, "period", 32'(period), 32'(exp_period(code)));
      hold   = (dv[2:1] == 2'b11);
      exp_pf = 1'b0;
      if (hold) mcnt = '0;
      else if (tbe) begin
         nxt = mcnt + 14'd1;
         if (code != 0 && pe && ((nxt & exp_mask(code)) == 14'd0)) exp_pf = 1'b1;
         mcnt = nxt;
      end
      if (code == 0)      tag = "R1";
      else if (hold)      tag = "R7";
      else if (!pe)       tag = "R6";
      else if (code <= 2) tag = "R2";
      else                tag = req;
      @(negedge clk);
      check(tag, "pf_set", 32'(pf_set), 32'(exp_pf));
      check("R5", "irq_set", 32'(irq_set), 32'(exp_pf));
   endtask

   initial begin : watchdog
      #1_500_000;
      fails++; checks++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
   end

   initial begin : main
      int unsigned seed;
      logic [3:0] rc;
      logic       pe;
      seed = $urandom(32'd20240);
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", "pf_set after reset", 32'(pf_set), 32'd0);
      check("R9", "irq_set after reset", 32'(irq_set), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: smallest period, every-cycle timebase
      for (int i = 0; i < 40; i++) step(1'b1, 4'd3, 1'b1, 3'b010, "R4");
      // R4: gaps in timebase
      for (int i = 0; i < 60; i++) step(i[0], 4'd4, 1'b1, 3'b010, "R4");
      // R6: enable off while count runs, then back on
      for (int i = 0; i < 50; i++) step(1'b1, 4'd5, 1'b0, 3'b010, "R6");
      for (int i = 0; i < 70; i++) step(1'b1, 4'd5, 1'b1, 3'b010, "R4");
      // R7: hold then release
      for (int i = 0; i < 6; i++)  step(1'b1, 4'd3, 1'b1, 3'b110, "R7");
      for (int i = 0; i < 12; i++) step(1'b1, 4'd3, 1'b1, 3'b010, "R7");
      // R8: rate change mid-period (32 -> 4)
      for (int i = 0; i < 20; i++) step(1'b1, 4'd6, 1'b1, 3'b010, "R8");
      for (int i = 0; i < 12; i++) step(1'b1, 4'd3, 1'b1, 3'b010, "R8");
      // R8: change to a slower rate mid-period (4 -> 64)
      for (int i = 0; i < 3; i++)  step(1'b1, 4'd3, 1'b1, 3'b010, "R8");
      for (int i = 0; i < 140; i++) step(1'b1, 4'd7, 1'b1, 3'b010, "R8");
      // R2: aliased codes
      for (int i = 0; i < 300; i++) step(1'b1, 4'd1, 1'b1, 3'b010, "R2");
      for (int i = 0; i < 600; i++) step(1'b1, 4'd2, 1'b1, 3'b010, "R2");
      // R1: code zero
      for (int i = 0; i < 50; i++) step(1'b1, 4'd0, 1'b1, 3'b010, "R1");
      // R3: longest period across a full count wrap
      for (int i = 0; i < 33000; i++) step(1'b1, 4'd15, 1'b1, 3'b010, "R3");
      // Random mix
      rc = 4'd3; pe = 1'b1;
      for (int i = 0; i < 20000; i++) begin
         if ($urandom % 64 == 0) begin
            int unsigned r = $urandom % 10;
            rc = (r == 0) ? 4'd0 : (r == 1) ? 4'd1 : (r == 2) ? 4'd2 : 4'(3 + r % 4);
         end
         if ($urandom % 32 == 0) pe = ($urandom % 6 != 0);
         step(($urandom % 3) != 0, rc, pe,
              ($urandom % 40 == 0) ? 3'b110 : 3'b010, "R4");
      end
      summary();
      $finish;
   end

endmodule